// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Sequencing

This block turns bytes into asynchronous serial frames on a single line. Each frame has a low start bit, eight data bits sent least significant first, an optional address bit used for multidrop addressing, and one high stop bit. Bytes enter through a valid/ready port into a one-entry holding register. A shift register sends them one bit per baud period. The baud period is set by an external single-cycle `baud_tick` pulse.

Three single-cycle command pulses steer the line:
- **Start break** drives the line low once all queued characters have gone out.
- **Stop break** ends the break. It never ends it before one full character time has passed.
- **Send address** marks the next accepted byte as an address character.

After every break the line is held high for a fixed idle gap before another frame may begin. Status pins report an empty holding register, a fully quiet transmitter and an active break.

Back-pressure rules:
- `wr_ready` is high only when the holding register is empty and no break is pending, active or in its gap.
- A byte is taken on any clock edge where both `wr_valid` and `wr_ready` are high.
- A producer may hold `wr_valid` high with stable data for as long as it likes.
- Nothing is lost while `wr_ready` is low.

Top module: `uart_brk_tx`

## Requirements
- R1: Out of reset `tx` is 1, `hold_empty` and `tx_empty` are 1, `brk_active` is 0 and `wr_ready` is 1.
- R2: A frame starts on a baud tick and each bit lasts one baud period. The bits in time order are: a start bit of 0, data bits 0 to 7 (LSB first), the address bit (multidrop builds only) and a stop bit of 1.
- R3: The holding register takes one byte per handshake, and `wr_ready` is 0 while it is full. A byte held there starts on the tick that ends the previous stop bit, so there is no idle time between frames. Writes are refused while a break is pending, active or in its gap.
- R4: After a send-address pulse, the next accepted byte goes out with address bit 1. Every other byte goes out with 0. Repeating the pulse before that write changes nothing.
- R5: After a start-break pulse, all characters already accepted go out first. The line then drops low on the first tick after the shifter has gone idle: one high bit period after the last stop bit, or on the next tick when nothing is queued.
- R6: A start-break pulse while a break is already low has no effect. No second break follows.
- R7: A stop-break pulse given before one character length (11 periods in the multidrop build) has elapsed is held. The line then stays low for exactly 11 bit periods.
- R8: A stop-break pulse given after the minimum ends the low level on the next baud tick.
- R9: After a break the line stays high for at least 12 bit periods before any frame starts. A byte offered during the break goes out after that gap.
- R10: A stop-break pulse while no break is pending or active is ignored. A break started later stays low until its own stop pulse.
- R11: `brk_active` is 1 exactly while the break holds the line low. `tx_empty` is 0 whenever a byte is held or shifting, or a break is pending, low or in its gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_ready | output | 1 | Holding register can accept a byte |
| wr_data | input | 8 | Byte to send |
| cmd_brk_start | input | 1 | Pulse: request a break |
| cmd_brk_stop | input | 1 | Pulse: request end of break |
| cmd_addr | input | 1 | Pulse: next byte is an address character |
| tx | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | No byte, break or gap in progress |
| brk_active | output | 1 | Break is driving the line low |

## Verification
- **Frame sweep.** The bench sends all 256 byte values with the address mark on some of them, so a swapped bit order or a sticky address flag shows up as a wrong decoded value.
- **Break timing from idle.** It starts a break with an early stop and measures the low and high run lengths. A design that honoured the stop at once would give a low pulse shorter than 11 periods, and one without the gap would start the queued byte too soon.
- **Break after queued bytes.** A break requested behind two queued bytes must appear only after both stop bits; cutting into a character corrupts it.
- **Stray commands.** A stop pulse given while idle must not pre-arm the next break, and a start pulse given during a break must not cause a second break.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    BRK_IDLE = 2'd0,
    BRK_PEND = 2'd1,
    BRK_LOW  = 2'd2,
    BRK_GAP  = 2'd3
  } brk_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ubt_hold.sv
module ubt_hold #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MULTIDROP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              cmd_addr,
  input  logic              accept_en,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] q_data,
  output logic              q_addr
);
  logic full_q, addr_flag_q, addr_q;
  logic [DATA_W-1:0] data_q;
  logic wr_fire, addr_cmd;

  assign addr_cmd = cmd_addr && (MULTIDROP != 0);
  assign wr_ready = !full_q && accept_en;
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q      <= 1'b0;
      addr_flag_q <= 1'b0;
      addr_q      <= 1'b0;
      data_q      <= '0;
    end else begin
      if (wr_fire) begin
        full_q <= 1'b1;
        data_q <= wr_data;
        addr_q <= addr_flag_q || addr_cmd;
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (wr_fire) addr_flag_q <= 1'b0;
      else if (addr_cmd) addr_flag_q <= 1'b1;
    end
  end

  assign full   = full_q;
  assign q_data = data_q;
  assign q_addr = addr_q;

  // R3: the shifter only takes a byte that is present
  p_take_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
  // R3: an accepted byte occupies the register on the next cycle
  p_accept_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (full_q && !wr_ready));
  // R4: the address mark is spent by the write that carries it
  p_addr_spent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !addr_flag_q);
endmodule

// File: rtl/ubt_shift.sv
module ubt_shift #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MULTIDROP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_ok,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_addr,
  output logic              take,
  output logic              busy,
  output logic              line
);
  localparam int unsigned FRAME_W = DATA_W + MULTIDROP + 2;
  localparam int unsigned CW      = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q, frame;
  logic [CW-1:0]      left_q;
  logic               busy_q, last;

  generate
    if (MULTIDROP != 0) begin : g_md
      assign frame = {1'b1, hold_addr, hold_data, 1'b0};
    end else begin : g_plain
      assign frame = {1'b1, hold_data, 1'b0};
    end
  endgenerate

  assign last = busy_q && (left_q == '0);
  assign take = tick && load_ok && hold_full && (!busy_q || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (tick) begin
      if (take) begin
        sr_q   <= frame;
        left_q <= LAST_IDX;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sr_q[0] : 1'b1;

  // R2: a load puts the start bit on the line at once
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (busy_q && !line));
  // R2: bits only change on a baud tick
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(line));
endmodule

// File: rtl/ubt_brk.sv
module ubt_brk
  import uart_brk_pkg::*;
#(
  parameter int unsigned CHAR_LEN = 11,
  parameter int unsigned GAP_BITS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmd_start,
  input  logic cmd_stop,
  input  logic hold_full,
  input  logic sh_busy,
  output logic accept_en,
  output logic load_ok,
  output logic low,
  output logic idle
);
  localparam int unsigned CMAX = max_u(CHAR_LEN, GAP_BITS);
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(CHAR_LEN - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_BITS - 1);
  localparam logic [CW-1:0] LOW_FULL = CW'(CHAR_LEN);
  localparam logic [CW-1:0] GAP_FULL = CW'(GAP_BITS);

  brk_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BRK_IDLE;
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      case (st_q)
        BRK_IDLE: begin
          stop_q <= 1'b0;
          if (cmd_start) st_q <= BRK_PEND;
        end
        BRK_PEND: begin
          if (cmd_stop) stop_q <= 1'b1;
          if (tick && !hold_full && !sh_busy) begin
            st_q  <= BRK_LOW;
            cnt_q <= '0;
          end
        end
        BRK_LOW: begin
          if (cmd_stop) stop_q <= 1'b1;
          if (tick) begin
            if ((stop_q || cmd_stop) && (cnt_q >= LOW_LAST)) begin
              st_q   <= BRK_GAP;
              cnt_q  <= '0;
              stop_q <= 1'b0;
            end else if (cnt_q < LOW_LAST) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        BRK_GAP: begin
          if (tick) begin
            if (cnt_q == GAP_LAST) st_q <= BRK_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= BRK_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == BRK_IDLE);
  assign accept_en = idle;
  assign load_ok   = (st_q == BRK_IDLE) || (st_q == BRK_PEND);
  assign low       = (st_q == BRK_LOW);

  logic in_gap;
  logic [CW-1:0] low_seen_q, gap_seen_q;
  assign in_gap = (st_q == BRK_GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_seen_q <= '0;
      gap_seen_q <= '0;
    end else begin
      if (!low) low_seen_q <= '0;
      else if (tick && low_seen_q != LOW_FULL) low_seen_q <= low_seen_q + 1'b1;
      if (!in_gap) gap_seen_q <= '0;
      else if (tick && gap_seen_q != GAP_FULL) gap_seen_q <= gap_seen_q + 1'b1;
    end
  end

  // R7: the low level lasts at least one character length
  p_low_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low) |-> (low_seen_q >= LOW_FULL));
  // R9: the idle gap lasts the full count of bit periods
  p_gap_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_gap) |-> (gap_seen_q >= GAP_FULL));
  // R5: the break begins only with both registers drained
  p_brk_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low) |-> $past(!hold_full && !sh_busy && tick));
  // R9: no character is loaded during the break or its gap
  p_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (low || in_gap) |-> !load_ok);
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MULTIDROP = 1,
  parameter int unsigned GAP_BITS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_brk_start,
  input  logic              cmd_brk_stop,
  input  logic              cmd_addr,
  output logic              tx,
  output logic              hold_empty,
  output logic              tx_empty,
  output logic              brk_active
);
  localparam int unsigned CHAR_LEN = DATA_W + MULTIDROP + 2;

  logic accept_en, load_ok, brk_low, brk_idle;
  logic take, hold_full, hold_addr, sh_busy, sh_line;
  logic [DATA_W-1:0] hold_data;

  ubt_hold #(.DATA_W(DATA_W), .MULTIDROP(MULTIDROP)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .cmd_addr(cmd_addr), .accept_en(accept_en),
    .take(take), .full(hold_full), .q_data(hold_data), .q_addr(hold_addr)
  );

  ubt_shift #(.DATA_W(DATA_W), .MULTIDROP(MULTIDROP)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load_ok(load_ok),
    .hold_full(hold_full), .hold_data(hold_data), .hold_addr(hold_addr),
    .take(take), .busy(sh_busy), .line(sh_line)
  );

  ubt_brk #(.CHAR_LEN(CHAR_LEN), .GAP_BITS(GAP_BITS)) u_brk (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cmd_start(cmd_brk_start),
    .cmd_stop(cmd_brk_stop), .hold_full(hold_full), .sh_busy(sh_busy),
    .accept_en(accept_en), .load_ok(load_ok), .low(brk_low), .idle(brk_idle)
  );

  assign tx         = brk_low ? 1'b0 : sh_line;
  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && !sh_busy && brk_idle;
  assign brk_active = brk_low;

  // R11: a quiet transmitter idles high and is ready for data
  p_empty_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (tx && !brk_active && wr_ready));
  // R11: the break and a frame never share the line
  p_brk_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |-> (!sh_busy && !tx));
endmodule

// File: tb/test_uart_brk_tx.sv
module test_uart_brk_tx;
  localparam int CL  = 11;
  localparam int GAP = 12;
  localparam int RMAX = 8192;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic cmd_brk_start = 1'b0, cmd_brk_stop = 1'b0, cmd_addr = 1'b0;
  logic wr_ready, tx, hold_empty, tx_empty, brk_active;

  uart_brk_tx i_uart_brk_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .cmd_brk_start(cmd_brk_start),
    .cmd_brk_stop(cmd_brk_stop), .cmd_addr(cmd_addr), .tx(tx),
    .hold_empty(hold_empty), .tx_empty(tx_empty), .brk_active(brk_active)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, rcount = 0;
  bit done = 1'b0;
  logic rec [0:RMAX-1];
  logic rec_brk [0:RMAX-1];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // baud tick every 4 clocks; line sampled once per bit period
  initial begin : ticker
    wait (rst_n);
    forever begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
      if (rcount < RMAX) begin
        rec[rcount] = tx;
        rec_brk[rcount] = brk_active;
        rcount++;
      end
      @(negedge clk);
      @(negedge clk);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    step(); cmd_brk_start = 1'b1; step(); cmd_brk_start = 1'b0;
  endtask
  task automatic pulse_stop();
    step(); cmd_brk_stop = 1'b1; step(); cmd_brk_stop = 1'b0;
  endtask
  task automatic pulse_addr();
    step(); cmd_addr = 1'b1; step(); cmd_addr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    step();
    while (!wr_ready) step();
    wr_valid = 1'b1;
    wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic wait_periods(input int n);
    int t;
    t = rcount + n;
    while (rcount < t) step();
  endtask

  task automatic wait_empty();
    while (!tx_empty) step();
    wait_periods(2);
  endtask

  function automatic int first_zero(input int from);
    for (int i = from; i < rcount; i++) if (rec[i] == 1'b0) return i;
    return RMAX - 32;
  endfunction

  function automatic int run_len(input int from, input logic v);
    int n;
    n = 0;
    for (int i = from; i < rcount; i++) begin
      if (rec[i] != v) break;
      n++;
    end
    return n;
  endfunction

  function automatic int get_byte(input int z);
    int v;
    v = 0;
    for (int i = 0; i < 8; i++) if (rec[z + 1 + i] == 1'b1) v = v | (1 << i);
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int base, z, zl, g, j, s;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(tx == 1'b1, "R1 tx idle", int'(tx), 1);
    check(hold_empty && tx_empty, "R1 empty flags", int'({hold_empty, tx_empty}), 3);
    check(!brk_active && wr_ready, "R1 brk/ready", int'({brk_active, wr_ready}), 1);
    rst_n = 1'b1;
    wait_periods(2);

    // R2/R4: every byte value, address mark on every third one
    for (int d = 0; d < 256; d++) begin
      bit a;
      a = (d % 3 == 0);
      base = rcount;
      if (a) begin pulse_addr(); pulse_addr(); end
      send_byte(d[7:0]);
      wait_empty();
      z = first_zero(base);
      check(get_byte(z) == d, "R2 data bits", get_byte(z), d);
      check(rec[z + 9] == a, "R4 address bit", int'(rec[z + 9]), int'(a));
      check(rec[z + 10] == 1'b1, "R2 stop bit", int'(rec[z + 10]), 1);
    end

    // R3: back-to-back frames, holding register back-pressure
    base = rcount;
    send_byte(8'h5A);
    send_byte(8'hC3);
    check(!wr_ready && !hold_empty, "R3 hold full", int'({wr_ready, hold_empty}), 0);
    check(!tx_empty, "R11 busy not empty", int'(tx_empty), 0);
    wait_empty();
    z = first_zero(base);
    check(get_byte(z) == 8'h5A, "R3 first frame", get_byte(z), 8'h5A);
    check(rec[z + 11] == 1'b0, "R3 no gap start", int'(rec[z + 11]), 0);
    check(get_byte(z + 11) == 8'hC3, "R3 second frame", get_byte(z + 11), 8'hC3);

    // R5/R7/R9/R6: break from idle with early stop, byte queued behind it
    base = rcount;
    pulse_start();
    pulse_stop();
    wait_periods(3);
    check(brk_active && !tx, "R11 break low flag", int'({brk_active, tx}), 2);
    check(!tx_empty && !wr_ready, "R3 refused in break", int'({tx_empty, wr_ready}), 0);
    pulse_start();
    send_byte(8'h3C);
    wait_empty();
    z = first_zero(base);
    check(z - base <= 2, "R5 idle break prompt", z - base, 2);
    zl = run_len(z, 1'b0);
    check(zl == CL, "R7 minimum low", zl, CL);
    check(rec_brk[z] && !rec_brk[z + zl], "R11 brk_active span",
          int'({rec_brk[z], rec_brk[z + zl]}), 2);
    g = run_len(z + zl, 1'b1);
    check(g >= GAP && g <= GAP + 1, "R9 gap length", g, GAP);
    check(get_byte(z + zl + g) == 8'h3C, "R9 byte after gap", get_byte(z + zl + g), 8'h3C);
    wait_periods(20);
    check(run_len(z + zl + g + CL, 1'b1) >= 18, "R6 no second break",
          run_len(z + zl + g + CL, 1'b1), 18);

    // R10/R5/R8: stray stop, break behind two bytes, late stop
    pulse_stop();
    base = rcount;
    send_byte(8'h81);
    send_byte(8'h7E);
    pulse_start();
    check(!wr_ready, "R3 refused while pending", int'(wr_ready), 0);
    while (!brk_active) step();
    wait_periods(30);
    step();
    j = rcount - 1;
    cmd_brk_stop = 1'b1;
    step();
    cmd_brk_stop = 1'b0;
    wait_empty();
    z = first_zero(base);
    check(get_byte(z) == 8'h81, "R5 first drained", get_byte(z), 8'h81);
    check(get_byte(z + 11) == 8'h7E, "R5 second drained", get_byte(z + 11), 8'h7E);
    s = z + 21;
    check(rec[s] == 1'b1 && rec[s + 1] == 1'b1 && rec[s + 2] == 1'b0, "R5 break after stop bit",
          int'({rec[s], rec[s + 1], rec[s + 2]}), 6);
    zl = run_len(s + 2, 1'b0);
    check(zl > CL, "R10 stray stop ignored", zl, CL + 1);
    check(zl == j - (s + 2) + 1, "R8 late stop", zl, j - (s + 2) + 1);
    check(tx_empty && tx, "R11 quiet after gap", int'({tx_empty, tx}), 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule